// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a word-interleaved scratchpad of 4096 words of 32 bits (16 KB), split into 16 single-port banks. One request carries 16 lanes, one for each thread of a half-warp. Each lane has a valid bit, a 12-bit word address, a write enable and 32 bits of write data. The bank is chosen by the low four address bits and the row inside the bank by the upper eight, so a run of consecutive words touches every bank once.

When a request arrives, the block counts how many valid lanes map to each bank. It then splits the request into as many single-cycle passes as the most heavily loaded bank needs. In every pass each bank serves at most one lane, always the lowest-numbered lane of that bank still waiting. Read results are gathered per lane in registers. A one-cycle `done` pulse marks the point where all of them are valid. The requester holds the lane inputs steady from the request cycle until `done`.

Top module: `smemBankedScratch`

## Requirements
- R1: Word address bits [3:0] select the bank and bits [11:4] select the row, so 4096 distinct addresses hold distinct words, including a run of addresses that wraps from 4095 to 0.
- R2: In any pass each bank serves at most one lane. Sixteen lanes whose addresses fall in sixteen different banks (stride 1, or any odd stride) complete in one pass.
- R3: A request whose most-loaded bank receives N valid lanes keeps `busy` high for exactly N cycles, starting the cycle after `reqValid` is sampled; `done` rises in the cycle in which `busy` falls.
- R4: A lane stride of s gives N = gcd(s,16) passes: stride 2 takes 2, stride 4 takes 4, stride 8 takes 8 and stride 16 takes 16.
- R5: `done` is high for exactly one cycle and is never high together with `busy`.
- R6: Lanes that share a bank are served in ascending lane order, so a read lane observes the write of any lower-numbered lane in the same request to the same address.
- R7: When several lanes of one request write the same address, the highest-numbered such lane's data remains stored.
- R8: At `done`, lane l's field of `rdData` (bits [32l+31:32l]) holds the stored word for a valid read lane, the word stored before its own write for a valid write lane, and zero for a lane whose valid bit is 0.
- R9: A request with no valid lane pulses `done` in the cycle after `reqValid` is sampled and never raises `busy`.
- R10: While `rstN` is low and after its release, `busy`, `done` and all of `rdData` are zero until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while the block is idle |
| laneValid | input | 16 | Per-lane valid, bit l for lane l |
| laneAddr | input | 192 | Per-lane word address, lane l in bits [12l+11:12l] |
| laneWe | input | 16 | Per-lane write enable, bit l for lane l |
| laneWdata | input | 512 | Per-lane write data, lane l in bits [32l+31:32l] |
| busy | output | 1 | High during each service pass |
| done | output | 1 | One-cycle pulse: all lanes served, read data valid |
| rdData | output | 512 | Per-lane read data, lane l in bits [32l+31:32l] |

## Verification
A grant register that drops or repeats a lane shows at the ports within the same request. The pass count seen on `busy` is wrong, or a lane's read word differs from the word a lane-ordered model expects, and `done` exposes both. A bank select built from the wrong address bits changes the pass count for the stride patterns on the first request that uses them. It also makes data read back at a wrapped address come from the wrong word. An arbiter that favours the wrong lane shows up in the read-after-write and write-after-write cases of a single request, where the read value or the surviving word changes.

// File: rtl/smemPkg.sv
package smemPkg;
  parameter int LANES  = 16;
  parameter int BANKS  = 16;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 12;

  localparam int BANK_W = $clog2(BANKS);
  localparam int LANE_W = $clog2(LANES);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;

  typedef enum logic {S_IDLE, S_RUN} smemState_t;

  // strobes from control to datapath for one pass
  typedef struct packed {
    logic                          clearRd;
    logic [LANES-1:0]              laneGrant;
    logic [BANKS-1:0]              bankEn;
    logic [BANKS-1:0][LANE_W-1:0]  bankLane;
  } smemStrobe_t;
endpackage

// File: rtl/smemGrantArb.sv
module smemGrantArb
  import smemPkg::*;
(
  input  logic [LANES-1:0]             pend,
  input  logic [LANES*ADDR_W-1:0]      laneAddr,
  output logic [LANES-1:0]             laneGrant,
  output logic [BANKS-1:0]             bankEn,
  output logic [BANKS-1:0][LANE_W-1:0] bankLane
);
  logic [LANES-1:0][BANK_W-1:0] laneBank;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneBank[l] = laneAddr[l*ADDR_W +: BANK_W];
    end
  end

  // per bank: lowest-numbered pending lane wins (scan from top down)
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankEn[b]   = 1'b0;
      bankLane[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend[l] && (laneBank[l] == BANK_W'(b))) begin
          bankEn[b]   = 1'b1;
          bankLane[b] = LANE_W'(l);
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneGrant[l] = pend[l] && bankEn[laneBank[l]] &&
                     (bankLane[laneBank[l]] == LANE_W'(l));
    end
  end
endmodule

// File: rtl/smemCtrl.sv
module smemCtrl
  import smemPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  output logic                    busy,
  output logic                    done,
  output smemStrobe_t             strb
);
  smemState_t                  state;
  logic [LANES-1:0]            pend;
  logic [LANES-1:0]            pendNext;
  logic [LANES-1:0]            grant;
  logic [BANKS-1:0]            bEn;
  logic [BANKS-1:0][LANE_W-1:0] bLane;

  smemGrantArb arb_i (
    .pend      (pend),
    .laneAddr  (laneAddr),
    .laneGrant (grant),
    .bankEn    (bEn),
    .bankLane  (bLane)
  );

  assign pendNext = pend & ~grant;
  assign busy     = (state == S_RUN);

  always_comb begin
    strb.clearRd   = (state == S_IDLE) && reqValid;
    strb.laneGrant = grant;
    strb.bankEn    = bEn;
    strb.bankLane  = bLane;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      pend  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reqValid) begin
            pend <= laneValid;
            if (laneValid != '0) state <= S_RUN;
            else                 done  <= 1'b1;
          end
        end
        S_RUN: begin
          pend <= pendNext;
          if (pendNext == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smemData.sv
module smemData
  import smemPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  smemStrobe_t             strb,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES-1:0]        laneWe,
  input  logic [LANES*DATA_W-1:0] laneWdata,
  output logic [LANES*DATA_W-1:0] rdData
);
  logic [BANKS-1:0][DATA_W-1:0] bankRd;
  logic [LANES-1:0][DATA_W-1:0] rdReg;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [ADDR_W-1:0] selAddr;
    logic              selWe;
    logic [DATA_W-1:0] selWd;

    assign selAddr   = laneAddr[strb.bankLane[b]*ADDR_W +: ADDR_W];
    assign selWe     = laneWe[strb.bankLane[b]];
    assign selWd     = laneWdata[strb.bankLane[b]*DATA_W +: DATA_W];
    assign bankRd[b] = mem[selAddr[ADDR_W-1:BANK_W]];

    always_ff @(posedge clk) begin
      if (strb.bankEn[b] && selWe) mem[selAddr[ADDR_W-1:BANK_W]] <= selWd;
    end
  end

  // read word is captured before the same pass's write lands
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (strb.clearRd) begin
      rdReg <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strb.laneGrant[l]) rdReg[l] <= bankRd[laneAddr[l*ADDR_W +: BANK_W]];
      end
    end
  end

  assign rdData = rdReg;
endmodule

// File: rtl/smemBankedScratch.sv
module smemBankedScratch
  import smemPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES-1:0]        laneWe,
  input  logic [LANES*DATA_W-1:0] laneWdata,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*DATA_W-1:0] rdData
);
  smemStrobe_t strb;

  smemCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .laneValid (laneValid),
    .laneAddr  (laneAddr),
    .busy      (busy),
    .done      (done),
    .strb      (strb)
  );

  smemData data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .laneAddr  (laneAddr),
    .laneWe    (laneWe),
    .laneWdata (laneWdata),
    .rdData    (rdData)
  );
endmodule

// File: rtl/smemChecker.sv
module smemChecker
  import smemPkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [LANES-1:0]        laneValid,
  input logic [LANES*ADDR_W-1:0] laneAddr,
  input logic                    busy,
  input logic                    done,
  input logic [LANES-1:0]        laneGrant,
  input logic [BANKS-1:0]        bankEn
);
  logic [7:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else       runLen <= busy ? runLen + 8'd1 : 8'd0;
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  p_fall_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_progress_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (laneGrant != '0));

  p_pass_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= 8'(LANES));

  p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (laneGrant & ~laneValid) == '0);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (bankEn == '0));

  p_hold_inputs_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(laneAddr) && $stable(laneValid)));

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    logic [LANES-1:0] inBank;
    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        inBank[l] = (laneAddr[l*ADDR_W +: BANK_W] == BANK_W'(b));
      end
    end
    p_one_per_bank_r2: assert property (@(posedge clk) disable iff (!rstN)
      $countones(laneGrant & inBank) <= 1);
  end
endmodule

bind smemBankedScratch smemChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .laneValid (laneValid),
  .laneAddr  (laneAddr),
  .busy      (busy),
  .done      (done),
  .laneGrant (strb.laneGrant),
  .bankEn    (strb.bankEn)
);

// File: tb/smemBankedScratch_tb.sv
`timescale 1ns/1ps
module smemBankedScratch_tb_top;
  localparam int LN = 16;
  localparam int AW = 12;
  localparam int DW = 32;

  // {stride, base, expected passes}
  localparam int VEC [10][3] = '{
    '{1, 0, 1}, '{3, 16, 1}, '{5, 7, 1}, '{2, 512, 2}, '{6, 700, 2},
    '{4, 1024, 4}, '{12, 1500, 4}, '{8, 2048, 8}, '{16, 3000, 16},
    '{1, 4088, 1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [LN-1:0]     laneValid = '0;
  logic [LN*AW-1:0]  laneAddr = '0;
  logic [LN-1:0]     laneWe = '0;
  logic [LN*DW-1:0]  laneWdata = '0;
  logic              busy;
  logic              done;
  logic [LN*DW-1:0]  rdData;

  int nChk = 0;
  int nFail = 0;

  logic [LN-1:0]    vMask;
  logic [AW-1:0]    aArr  [LN];
  logic             weArr [LN];
  logic [DW-1:0]    wdArr [LN];
  logic [DW-1:0]    model [4096];

  always #2.5 clk = ~clk;

  smemBankedScratch dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .laneValid(laneValid),
    .laneAddr(laneAddr), .laneWe(laneWe), .laneWdata(laneWdata),
    .busy(busy), .done(done), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clearLanes();
    vMask = '0;
    for (int l = 0; l < LN; l++) begin
      aArr[l] = '0; weArr[l] = 1'b0; wdArr[l] = '0;
    end
  endtask

  // drive one request, compare pass count and every lane's read word
  task automatic runReq(input string tag, input int expN);
    logic [DW-1:0] expRd [LN];
    int cyc;
    int guard;
    for (int l = 0; l < LN; l++) begin
      if (!vMask[l]) expRd[l] = '0;
      else begin
        expRd[l] = model[aArr[l]];
        if (weArr[l]) model[aArr[l]] = wdArr[l];
      end
    end
    @(negedge clk);
    laneValid = vMask;
    for (int l = 0; l < LN; l++) begin
      laneAddr[l*AW +: AW]  = aArr[l];
      laneWe[l]             = weArr[l];
      laneWdata[l*DW +: DW] = wdArr[l];
    end
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 0;
    guard = 0;
    while (!done && guard < 64) begin
      if (busy) cyc++;
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, {tag, " R3 done seen"}, done, 1);
    check(cyc == expN, {tag, " R3 pass count"}, cyc, expN);
    for (int l = 0; l < LN; l++) begin
      check(rdData[l*DW +: DW] == expRd[l], {tag, " R8 lane data"},
            rdData[l*DW +: DW], expRd[l]);
    end
    @(negedge clk);
    check(!done && !busy, {tag, " R5 done one cycle"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired R3 act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) model[i] = '0;
    clearLanes();
    repeat (3) @(negedge clk);
    check(!busy && !done, "R10 reset busy/done", {busy, done}, 0);
    check(rdData == '0, "R10 reset rdData", rdData[31:0], 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && rdData == '0, "R10 idle after reset", {busy, done}, 0);

    // table walk: write then read back each stride pattern
    for (int i = 0; i < 10; i++) begin
      clearLanes();
      vMask = '1;
      for (int l = 0; l < LN; l++) begin
        aArr[l]  = AW'(VEC[i][1] + l * VEC[i][0]);
        weArr[l] = 1'b1;
        wdArr[l] = 32'hA500_0000 ^ DW'(i << 16) ^ DW'(l << 8) ^ DW'(aArr[l]);
      end
      runReq("R2 R4 write", VEC[i][2]);
      for (int l = 0; l < LN; l++) weArr[l] = 1'b0;
      runReq("R1 R4 read", VEC[i][2]);
    end

    // R9: no valid lane
    clearLanes();
    runReq("R9 empty", 0);

    // R7: every lane writes address 100, then lane 5 reads it
    clearLanes();
    vMask = '1;
    for (int l = 0; l < LN; l++) begin
      aArr[l] = 12'd100; weArr[l] = 1'b1; wdArr[l] = 32'h7700_0000 + DW'(l);
    end
    runReq("R7 same-address writes", 16);
    clearLanes();
    vMask = 16'h0020;
    aArr[5] = 12'd100;
    runReq("R7 survivor read", 1);
    check(rdData[5*DW +: DW] == 32'h7700_000F, "R7 highest lane kept",
          rdData[5*DW +: DW], 32'h7700_000F);

    // R6 setup: known contents at 200 and 201
    clearLanes();
    vMask = 16'h0003;
    aArr[0] = 12'd200; weArr[0] = 1'b1; wdArr[0] = 32'hC0C0_0000;
    aArr[1] = 12'd201; weArr[1] = 1'b1; wdArr[1] = 32'hC1C1_0001;
    runReq("R6 setup", 1);
    clearLanes();
    vMask = 16'h001F;
    aArr[0] = 12'd200; weArr[0] = 1'b1; wdArr[0] = 32'hDEAD_0001;
    aArr[1] = 12'd200;
    aArr[2] = 12'd200; weArr[2] = 1'b1; wdArr[2] = 32'hBEEF_0002;
    aArr[3] = 12'd200;
    aArr[4] = 12'd201;
    runReq("R6 lane order", 4);
    check(rdData[1*DW +: DW] == 32'hDEAD_0001, "R6 read sees lane0 write",
          rdData[1*DW +: DW], 32'hDEAD_0001);
    check(rdData[3*DW +: DW] == 32'hBEEF_0002, "R6 read sees lane2 write",
          rdData[3*DW +: DW], 32'hBEEF_0002);
    check(rdData[0*DW +: DW] == 32'hC0C0_0000, "R8 write lane returns old word",
          rdData[0*DW +: DW], 32'hC0C0_0000);

    // R8: partial mask, invalid lanes read zero
    clearLanes();
    vMask = 16'h00F0;
    for (int l = 0; l < LN; l++) aArr[l] = AW'(l);
    runReq("R8 partial mask", 1);
    check(rdData[0 +: DW] == '0, "R8 invalid lane zero", rdData[0 +: DW], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule